// File: doc/BRIEF.md
# Doubleword Byte Permute and Rotate Unit

This block is a one-stage permutation unit for a 64-bit execution pipeline. It takes a 64-bit source operand, a 5-bit shift amount and a 2-bit operation code. It forms one of four fixed data rearrangements: a rotate right by 32 plus the shift amount, a byte swap inside the halfwords of the low word with sign extension, a byte swap inside all four halfwords of the doubleword, or a reversal of the four halfwords. All four are combinational. The chosen result is captured in an output register.

The upstream stage raises `in_valid` for each operation it wants performed. The result and `out_valid` show on the next clock edge. While `in_valid` is low the last result stays on the output and `out_valid` drops. The unit has no stall path, so a new operation can be accepted on every cycle.

Top module: `dw_permute_unit`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge (synchronous, active-low), the edge clears `out_valid` to 0 and `result` to 0.
- R2: With `op_sel` = 2'b00 the result is the source rotated right by (32 + `shamt`) bit positions, so the rotate amount is between 32 and 63.
- R3: With `op_sel` = 2'b00 and `shamt` = 0 the result is the source with its upper and lower 32-bit words exchanged.
- R4: With `op_sel` = 2'b01 the low 32 bits of the result are the low word of the source with the two bytes of each 16-bit halfword exchanged. Result bits 63:32 all copy result bit 31, which is source bit 23.
- R5: With `op_sel` = 2'b10 each of the four 16-bit halfwords of the source has its two bytes exchanged in place. There is no sign extension.
- R6: With `op_sel` = 2'b11 result halfword k (bits 16k+15:16k) equals source halfword 3-k, for k = 0..3.
- R7: `out_valid` is high in exactly the cycle after a clock edge at which `in_valid` was high, and low after an edge at which `in_valid` was low.
- R8: When `in_valid` is low at a clock edge, `result` keeps its previous value.
- R9: `shamt` has no effect on the result for `op_sel` values 2'b01, 2'b10 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture the operation presented this cycle |
| src_operand | input | 64 | Source doubleword |
| shamt | input | 5 | Extra rotate amount added to 32 |
| op_sel | input | 2 | 00 rotate, 01 word byte swap, 10 doubleword byte swap, 11 halfword reverse |
| out_valid | output | 1 | Result register holds a newly captured result |
| result | output | 64 | Registered permutation result |

## Verification
Two things can happen in the same cycle: the output register presents one result while it captures the next. The bench provokes this with long runs of back-to-back random operations that mix all four codes. Each output is checked one edge after its own inputs, so a result that came from the wrong cycle or the wrong operation shows up as a mismatch. Idle gaps placed between these runs check that the output holds its value and that `out_valid` drops between overlapping captures.

// File: rtl/dw_permute_pkg.sv
package dw_permute_pkg;

  typedef enum logic [1:0] {
    PERM_ROTATE   = 2'b00,
    PERM_WORD_BSW = 2'b01,
    PERM_DWRD_BSW = 2'b10,
    PERM_HALF_REV = 2'b11
  } perm_op_e;

  // Exchange the two bytes of one 16-bit halfword.
  function automatic logic [15:0] swap_half_bytes(input logic [15:0] h);
    return {h[7:0], h[15:8]};
  endfunction

endpackage

// File: rtl/perm_rotator.sv
module perm_rotator #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  data_in,
  input  logic [SHAMT_W-1:0] amount,
  output logic [DATA_W-1:0]  data_out
);
  localparam int BASE  = DATA_W / 2;
  localparam int AMT_W = $clog2(DATA_W);

  logic [AMT_W-1:0]    eff_amt;
  logic [2*DATA_W-1:0] doubled;
  logic [2*DATA_W-1:0] shifted;

  // Fixed half-width offset plus the variable amount (32..63 by default).
  assign eff_amt  = AMT_W'(BASE) + AMT_W'(amount);
  assign doubled  = {data_in, data_in};
  assign shifted  = doubled >> eff_amt;
  assign data_out = shifted[DATA_W-1:0];
endmodule

// File: rtl/perm_byte_swapper.sv
module perm_byte_swapper
  import dw_permute_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SWAP_W   = 32,
  parameter bit SIGN_EXT = 1'b1
) (
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out
);
  localparam int NUM_HALVES = SWAP_W / 16;

  logic [SWAP_W-1:0] swapped;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign swapped[h*16 +: 16] = swap_half_bytes(data_in[h*16 +: 16]);
  end

  if (SWAP_W == DATA_W) begin : g_full
    assign data_out = swapped;
  end else if (SIGN_EXT) begin : g_sext
    assign data_out = {{(DATA_W-SWAP_W){swapped[SWAP_W-1]}}, swapped};
  end else begin : g_zext
    assign data_out = {{(DATA_W-SWAP_W){1'b0}}, swapped};
  end
endmodule

// File: rtl/perm_half_reverser.sv
module perm_half_reverser #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out
);
  localparam int WORD_W  = DATA_W / 2;
  localparam int HWORD_W = WORD_W / 2;

  logic [DATA_W-1:0] words_swapped;

  // Step one: exchange the halfwords inside each word.
  for (genvar w = 0; w < 2; w++) begin : g_word
    assign words_swapped[w*WORD_W +: HWORD_W]           = data_in[w*WORD_W+HWORD_W +: HWORD_W];
    assign words_swapped[w*WORD_W+HWORD_W +: HWORD_W]   = data_in[w*WORD_W +: HWORD_W];
  end

  // Step two: exchange the two words.
  assign data_out = {words_swapped[WORD_W-1:0], words_swapped[DATA_W-1:WORD_W]};
endmodule

// File: rtl/dw_permute_unit.sv
module dw_permute_unit
  import dw_permute_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  src_operand,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [1:0]         op_sel,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result
);
  localparam int WORD_W   = DATA_W / 2;
  localparam int HWORD_W  = WORD_W / 2;
  localparam int SIGN_SRC = WORD_W - 9;

  perm_op_e          op_e;
  logic [DATA_W-1:0] rot_res;
  logic [DATA_W-1:0] wswap_res;
  logic [DATA_W-1:0] dswap_res;
  logic [DATA_W-1:0] hrev_res;
  logic [DATA_W-1:0] sel_res;
  logic              capture_evt;
  logic              valid_q;
  logic [DATA_W-1:0] result_q;

  assign op_e        = perm_op_e'(op_sel);
  assign capture_evt = in_valid;

  perm_rotator #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) rot_i (
    .data_in(src_operand), .amount(shamt), .data_out(rot_res)
  );

  perm_byte_swapper #(.DATA_W(DATA_W), .SWAP_W(WORD_W), .SIGN_EXT(1'b1)) wsw_i (
    .data_in(src_operand), .data_out(wswap_res)
  );

  perm_byte_swapper #(.DATA_W(DATA_W), .SWAP_W(DATA_W), .SIGN_EXT(1'b0)) dsw_i (
    .data_in(src_operand), .data_out(dswap_res)
  );

  perm_half_reverser #(.DATA_W(DATA_W)) hrv_i (
    .data_in(src_operand), .data_out(hrev_res)
  );

  always_comb begin
    unique case (op_e)
      PERM_ROTATE:   sel_res = rot_res;
      PERM_WORD_BSW: sel_res = wswap_res;
      PERM_DWRD_BSW: sel_res = dswap_res;
      PERM_HALF_REV: sel_res = hrev_res;
      default:       sel_res = rot_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= capture_evt;
      if (capture_evt) result_q <= sel_res;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;

  // Reset clears the output stage (R1).
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));

  // Zero extra amount exchanges the words (R3).
  p_word_exchange_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b00 && shamt == '0) |=>
      result == {$past(src_operand[WORD_W-1:0]), $past(src_operand[DATA_W-1:WORD_W])});

  // Upper word follows source bit 23 after a word byte swap (R4).
  p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b01) |=>
      result[DATA_W-1:WORD_W] == {WORD_W{$past(src_operand[SIGN_SRC])}});

  // Lowest result halfword comes from the top source halfword (R6).
  p_half_rev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11) |=>
      result[HWORD_W-1:0] == $past(src_operand[DATA_W-1:DATA_W-HWORD_W]));

  // Valid follows the capture strobe by one cycle (R7).
  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // Idle cycles keep the result (R8).
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

// File: tb/dw_permute_unit_tb_top.sv
`timescale 1ns/1ps
module dw_permute_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_operand = '0;
  logic [4:0]  shamt = '0;
  logic [1:0]  op_sel = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  logic [63:0] last_exp = '0;

  always #4 clk = ~clk;

  dw_permute_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_operand(src_operand),
    .shamt(shamt), .op_sel(op_sel), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_rotate(input logic [63:0] x, input logic [4:0] s);
    logic [63:0] r;
    int n = 32 + int'(s);
    for (int i = 0; i < 64; i++) r[i] = x[(i + n) % 64];
    return r;
  endfunction

  function automatic logic [63:0] ref_bswap(input logic [63:0] x, input int nbytes);
    logic [63:0] r = '0;
    for (int b = 0; b < nbytes; b++) r[8*b +: 8] = x[8*(b ^ 1) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] ref_result(input logic [1:0] op, input logic [63:0] x,
                                             input logic [4:0] s);
    logic [63:0] r;
    case (op)
      2'd0: r = ref_rotate(x, s);
      2'd1: begin
        r = ref_bswap(x, 4);
        r[63:32] = r[31] ? 32'hFFFF_FFFF : 32'h0;
      end
      2'd2: r = ref_bswap(x, 8);
      default: for (int k = 0; k < 4; k++) r[16*k +: 16] = x[16*(3-k) +: 16];
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic v, input logic [1:0] op,
                       input logic [63:0] x, input logic [4:0] s);
    @(negedge clk);
    in_valid = v; op_sel = op; src_operand = x; shamt = s;
    @(posedge clk);
    #1;
    if (v) last_exp = ref_result(op, x, s);
    check({req, " R7 out_valid"}, {63'd0, out_valid}, {63'd0, v});
    check({req, " result"}, result, last_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // Directed corners
    apply("R3 zero amount", 1'b1, 2'b00, 64'h0123_4567_89AB_CDEF, 5'd0);
    check("R3 words exchanged", result, 64'h89AB_CDEF_0123_4567);
    apply("R2 max amount", 1'b1, 2'b00, 64'h8000_0000_0000_0001, 5'd31);
    check("R2 rotate 63", result, 64'h0000_0000_0000_0003);
    apply("R4 sign set", 1'b1, 2'b01, 64'h1234_5678_0080_0000, 5'd7);
    check("R4 negative word", result, 64'hFFFF_FFFF_8000_0000);
    apply("R4 sign clear", 1'b1, 2'b01, 64'hFFFF_FFFF_FF7F_FFFF, 5'd0);
    check("R4 positive word", result, 64'h0000_0000_7FFF_FFFF);
    apply("R5 dword swap", 1'b1, 2'b10, 64'h0011_2233_4455_6677, 5'd3);
    check("R5 bytes", result, 64'h1100_3322_5544_7766);
    apply("R6 half reverse", 1'b1, 2'b11, 64'hAAAA_BBBB_CCCC_DDDD, 5'd0);
    check("R6 halves", result, 64'hDDDD_CCCC_BBBB_AAAA);
    apply("R8 idle hold", 1'b0, 2'b00, 64'hDEAD_BEEF_DEAD_BEEF, 5'd9);
    check("R8 held", result, 64'hDDDD_CCCC_BBBB_AAAA);

    // shamt ignored for non-rotate codes
    for (int op = 1; op < 4; op++) begin
      logic [63:0] first;
      apply("R9 shamt a", 1'b1, 2'(op), 64'hF0E1_D2C3_B4A5_9687, 5'd0);
      first = result;
      apply("R9 shamt b", 1'b1, 2'(op), 64'hF0E1_D2C3_B4A5_9687, 5'd29);
      check("R9 shamt no effect", result, first);
    end

    // Random back-to-back runs with occasional idle gaps
    for (int i = 0; i < 2000; i++) begin
      logic v = ($urandom % 8) != 0;
      apply("R2 R4 R5 R6 R8 random", v, 2'($urandom), {$urandom, $urandom}, 5'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule